// File: doc/BRIEF.md
# Data Access Breakpoint Unit

This block watches the load/store traffic of a processor core and raises a debug request when an access matches one of a set of programmable watch slots. Each slot compares the access's virtual address under a per-bit mask. It can also compare the address-space identifier, reject loads or stores, require that the access touches chosen byte lanes, and compare the data value with some byte lanes left out of the compare. A store is compared against its write data in the cycle the access is presented. A load that needs a data compare waits for its returned data and is judged in the cycle that data is valid.

A hit on a slot sets a sticky per-slot flag. Depending on the slot's enables, the hit also raises the debug-exception request, the slot's trigger output, or both. The slot registers sit behind a small register port that responds only while the core is in debug mode. A hard reset and a soft reset have the same effect. The unit holds between 1 and 15 slots.

Top module: `dbrk_unit`

## Requirements
- R1: Address match: a slot hits only if the access address equals the slot address in every bit where the slot's address mask is 0. A mask bit of 1 removes that bit from the compare.
- R2: When the slot's use-ASID control (CTRL bit 4) is 1, the access ASID must equal the slot ASID. When that bit is 0, the ASID is not compared.
- R3: CTRL bit 2 set blocks hits from loads, and CTRL bit 3 set blocks hits from stores.
- R4: The access byte enables must share at least one set bit with the slot's lane enables (CTRL bits 8 and up, one bit per byte lane).
- R5: When the use-data control (CTRL bit 5) is 1, a store hits only if the write data equals the slot data on every byte lane whose data-mask bit (CTRL bits 16 and up) is 0.
- R6: A load on a slot with use-data set is held pending. It is judged against the read data in the first cycle that `ld_valid` is high, and its hit is reported in the following cycle.
- R7: Outputs are registered and appear one cycle after the hit. `brk_req` pulses for hits on slots with CTRL bit 0 set, and `trig_out[i]` pulses for hits on slot i when CTRL bit 1 is set. A slot with neither enable never hits.
- R8: A hit sets `match_status[i]`, which stays set until software writes 1 to that bit of the status register. A hit and a clear that fall in the same cycle leave the bit set.
- R9: Register writes are ignored and reads return 0 unless `debug_mode` is 1.
- R10: `rst_n` low and a synchronous `soft_rst` both clear every slot register, every status bit, every pending load and every output.
- R11: Register map: `reg_addr[7:4]` selects the slot and `reg_addr[3:0]` selects the field (0 address, 1 address mask, 2 ASID, 3 CTRL, 4 data). Address 0xF0 is the status register. Slot numbers at or above the slot count are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset, same effect as rst_n |
| debug_mode | input | 1 | Core is in debug mode; gates the register port |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Register write when 1, read when 0 |
| reg_addr | input | 8 | Slot and field select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| acc_valid | input | 1 | A load/store access is presented |
| acc_store | input | 1 | 1 store, 0 load |
| acc_addr | input | AW | Access virtual address |
| acc_asid | input | ASIDW | Access address-space identifier |
| acc_be | input | DW/8 | Byte lanes touched by the access |
| acc_wdata | input | DW | Store data |
| ld_valid | input | 1 | Read data for the outstanding load is valid |
| ld_data | input | DW | Load read data |
| brk_req | output | 1 | Debug-exception request |
| trig_out | output | NUM_SLOTS | Per-slot trigger pulses |
| match_status | output | NUM_SLOTS | Sticky per-slot match flags |

## Verification
Two functions can land on the same status bit in one cycle: a new hit that sets the bit and a write-one-to-clear from the register port. The bench makes this happen by placing a matching store and a status write that clears that bit in the same clock cycle. It then requires the bit to still be set afterwards. The bench also makes the deferred load compare finish a few cycles after its access, and checks that the request appears exactly one cycle after `ld_valid` and never at the time of the access.

// File: rtl/dbrk_pkg.sv
`timescale 1ns/1ps
package dbrk_pkg;
    localparam int REG_W = 32;

    localparam logic [3:0] FLD_ADDR   = 4'h0;
    localparam logic [3:0] FLD_AMASK  = 4'h1;
    localparam logic [3:0] FLD_ASID   = 4'h2;
    localparam logic [3:0] FLD_CTRL   = 4'h3;
    localparam logic [3:0] FLD_DATA   = 4'h4;
    localparam logic [3:0] STATUS_SEL = 4'hF;

    localparam int CB_BRK      = 0;
    localparam int CB_TRIG     = 1;
    localparam int CB_IGN_LD   = 2;
    localparam int CB_IGN_ST   = 3;
    localparam int CB_USE_ASID = 4;
    localparam int CB_USE_DATA = 5;
    localparam int LANE_LSB    = 8;
    localparam int DMASK_LSB   = 16;

    typedef struct packed {
        logic use_data;
        logic use_asid;
        logic ign_st;
        logic ign_ld;
        logic trig_en;
        logic brk_en;
    } slot_ctl_t;
endpackage

// File: rtl/dbrk_slot_match.sv
`timescale 1ns/1ps
module dbrk_slot_match
    import dbrk_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int ASIDW = 8
) (
    input  slot_ctl_t        ctl,
    input  logic [AW-1:0]    s_addr,
    input  logic [AW-1:0]    s_amask,
    input  logic [ASIDW-1:0] s_asid,
    input  logic [DW/8-1:0]  s_lanes,
    input  logic [DW/8-1:0]  s_dmask,
    input  logic [DW-1:0]    s_data,
    input  logic             acc_valid,
    input  logic             acc_store,
    input  logic [AW-1:0]    acc_addr,
    input  logic [ASIDW-1:0] acc_asid,
    input  logic [DW/8-1:0]  acc_be,
    input  logic [DW-1:0]    acc_wdata,
    input  logic [DW-1:0]    ld_data,
    output logic             st_hit,
    output logic             ld_now,
    output logic             ld_arm,
    output logic             ld_eq
);
    localparam int BL = DW / 8;

    logic [BL-1:0] wr_lane_ok, rd_lane_ok;
    logic          active, type_ok, lane_ok, addr_ok, asid_ok, qual;

    for (genvar g = 0; g < BL; g++) begin : g_lane
        assign wr_lane_ok[g] = s_dmask[g] | (acc_wdata[g*8 +: 8] == s_data[g*8 +: 8]);
        assign rd_lane_ok[g] = s_dmask[g] | (ld_data[g*8 +: 8] == s_data[g*8 +: 8]);
    end

    always_comb begin
        active  = ctl.brk_en | ctl.trig_en;
        type_ok = acc_store ? !ctl.ign_st : !ctl.ign_ld;
        lane_ok = |(acc_be & s_lanes);
        addr_ok = ((acc_addr ^ s_addr) & ~s_amask) == '0;
        asid_ok = !ctl.use_asid || (acc_asid == s_asid);
        qual    = acc_valid & active & type_ok & lane_ok & addr_ok & asid_ok;
        st_hit  = qual & acc_store & (!ctl.use_data | (&wr_lane_ok));
        ld_now  = qual & !acc_store & !ctl.use_data;
        ld_arm  = qual & !acc_store & ctl.use_data;
        ld_eq   = &rd_lane_ok;
    end
endmodule

// File: rtl/dbrk_regs.sv
`timescale 1ns/1ps
module dbrk_regs
    import dbrk_pkg::*;
#(
    parameter int NUM_SLOTS = 2,
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int ASIDW     = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                soft_rst,
    input  logic                                debug_mode,
    input  logic                                reg_en,
    input  logic                                reg_we,
    input  logic [7:0]                          reg_addr,
    input  logic [REG_W-1:0]                    reg_wdata,
    output logic [REG_W-1:0]                    reg_rdata,
    input  logic [NUM_SLOTS-1:0]                hit,
    output slot_ctl_t [NUM_SLOTS-1:0]           ctl,
    output logic [NUM_SLOTS-1:0][AW-1:0]        s_addr,
    output logic [NUM_SLOTS-1:0][AW-1:0]        s_amask,
    output logic [NUM_SLOTS-1:0][ASIDW-1:0]     s_asid,
    output logic [NUM_SLOTS-1:0][DW/8-1:0]      s_lanes,
    output logic [NUM_SLOTS-1:0][DW/8-1:0]      s_dmask,
    output logic [NUM_SLOTS-1:0][DW-1:0]        s_data,
    output logic [NUM_SLOTS-1:0]                status
);
    localparam int BL = DW / 8;

    typedef struct packed {
        logic [NUM_SLOTS-1:0][AW-1:0]    addr;
        logic [NUM_SLOTS-1:0][AW-1:0]    amask;
        logic [NUM_SLOTS-1:0][ASIDW-1:0] asid;
        slot_ctl_t [NUM_SLOTS-1:0]       ctl;
        logic [NUM_SLOTS-1:0][BL-1:0]    lanes;
        logic [NUM_SLOTS-1:0][BL-1:0]    dmask;
        logic [NUM_SLOTS-1:0][DW-1:0]    data;
        logic [NUM_SLOTS-1:0]            status;
    } regs_t;

    regs_t q, d;

    logic                 port_ok, wr;
    logic [3:0]           sel, fld;
    logic [NUM_SLOTS-1:0] clr;

    always_comb begin
        port_ok = reg_en & debug_mode;
        wr      = port_ok & reg_we;
        sel     = reg_addr[7:4];
        fld     = reg_addr[3:0];
        clr     = (wr && sel == STATUS_SEL && fld == FLD_ADDR) ? reg_wdata[NUM_SLOTS-1:0] : '0;

        d = q;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (wr && sel == 4'(i)) begin
                case (fld)
                    FLD_ADDR:  d.addr[i]  = reg_wdata[AW-1:0];
                    FLD_AMASK: d.amask[i] = reg_wdata[AW-1:0];
                    FLD_ASID:  d.asid[i]  = reg_wdata[ASIDW-1:0];
                    FLD_CTRL: begin
                        d.ctl[i].brk_en   = reg_wdata[CB_BRK];
                        d.ctl[i].trig_en  = reg_wdata[CB_TRIG];
                        d.ctl[i].ign_ld   = reg_wdata[CB_IGN_LD];
                        d.ctl[i].ign_st   = reg_wdata[CB_IGN_ST];
                        d.ctl[i].use_asid = reg_wdata[CB_USE_ASID];
                        d.ctl[i].use_data = reg_wdata[CB_USE_DATA];
                        d.lanes[i]        = reg_wdata[LANE_LSB +: BL];
                        d.dmask[i]        = reg_wdata[DMASK_LSB +: BL];
                    end
                    FLD_DATA:  d.data[i]  = reg_wdata[DW-1:0];
                    default: ;
                endcase
            end
        end
        // a hit in the same cycle as a clear keeps the flag
        d.status = (q.status & ~clr) | hit;
        if (soft_rst) d = '0;
    end

    always_comb begin
        reg_rdata = '0;
        if (port_ok) begin
            if (sel == STATUS_SEL && fld == FLD_ADDR) begin
                reg_rdata[NUM_SLOTS-1:0] = q.status;
            end
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (sel == 4'(i)) begin
                    case (fld)
                        FLD_ADDR:  reg_rdata[AW-1:0]    = q.addr[i];
                        FLD_AMASK: reg_rdata[AW-1:0]    = q.amask[i];
                        FLD_ASID:  reg_rdata[ASIDW-1:0] = q.asid[i];
                        FLD_CTRL: begin
                            reg_rdata[CB_BRK]            = q.ctl[i].brk_en;
                            reg_rdata[CB_TRIG]           = q.ctl[i].trig_en;
                            reg_rdata[CB_IGN_LD]         = q.ctl[i].ign_ld;
                            reg_rdata[CB_IGN_ST]         = q.ctl[i].ign_st;
                            reg_rdata[CB_USE_ASID]       = q.ctl[i].use_asid;
                            reg_rdata[CB_USE_DATA]       = q.ctl[i].use_data;
                            reg_rdata[LANE_LSB +: BL]    = q.lanes[i];
                            reg_rdata[DMASK_LSB +: BL]   = q.dmask[i];
                        end
                        FLD_DATA:  reg_rdata[DW-1:0]    = q.data[i];
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ctl     = q.ctl;
    assign s_addr  = q.addr;
    assign s_amask = q.amask;
    assign s_asid  = q.asid;
    assign s_lanes = q.lanes;
    assign s_dmask = q.dmask;
    assign s_data  = q.data;
    assign status  = q.status;
endmodule

// File: rtl/dbrk_unit.sv
`timescale 1ns/1ps
module dbrk_unit
    import dbrk_pkg::*;
#(
    parameter int NUM_SLOTS = 2,
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int ASIDW     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_rst,
    input  logic                 debug_mode,
    input  logic                 reg_en,
    input  logic                 reg_we,
    input  logic [7:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 acc_valid,
    input  logic                 acc_store,
    input  logic [AW-1:0]        acc_addr,
    input  logic [ASIDW-1:0]     acc_asid,
    input  logic [DW/8-1:0]      acc_be,
    input  logic [DW-1:0]        acc_wdata,
    input  logic                 ld_valid,
    input  logic [DW-1:0]        ld_data,
    output logic                 brk_req,
    output logic [NUM_SLOTS-1:0] trig_out,
    output logic [NUM_SLOTS-1:0] match_status
);
    localparam int BL = DW / 8;

    typedef struct packed {
        logic [NUM_SLOTS-1:0] pend;
        logic                 brk;
        logic [NUM_SLOTS-1:0] trig;
    } top_t;

    top_t q, d;

    slot_ctl_t [NUM_SLOTS-1:0]       ctl;
    logic [NUM_SLOTS-1:0][AW-1:0]    s_addr, s_amask;
    logic [NUM_SLOTS-1:0][ASIDW-1:0] s_asid;
    logic [NUM_SLOTS-1:0][BL-1:0]    s_lanes, s_dmask;
    logic [NUM_SLOTS-1:0][DW-1:0]    s_data;
    logic [NUM_SLOTS-1:0]            st_hit, ld_now, ld_arm, ld_eq, hit;
    logic [NUM_SLOTS-1:0]            brk_mask, trig_mask;

    dbrk_regs #(.NUM_SLOTS(NUM_SLOTS), .AW(AW), .DW(DW), .ASIDW(ASIDW)) u_regs (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .debug_mode(debug_mode),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .hit(hit), .ctl(ctl), .s_addr(s_addr), .s_amask(s_amask),
        .s_asid(s_asid), .s_lanes(s_lanes), .s_dmask(s_dmask), .s_data(s_data),
        .status(match_status)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        dbrk_slot_match #(.AW(AW), .DW(DW), .ASIDW(ASIDW)) u_match (
            .ctl(ctl[s]), .s_addr(s_addr[s]), .s_amask(s_amask[s]), .s_asid(s_asid[s]),
            .s_lanes(s_lanes[s]), .s_dmask(s_dmask[s]), .s_data(s_data[s]),
            .acc_valid(acc_valid), .acc_store(acc_store), .acc_addr(acc_addr),
            .acc_asid(acc_asid), .acc_be(acc_be), .acc_wdata(acc_wdata), .ld_data(ld_data),
            .st_hit(st_hit[s]), .ld_now(ld_now[s]), .ld_arm(ld_arm[s]), .ld_eq(ld_eq[s])
        );
        assign brk_mask[s]  = ctl[s].brk_en;
        assign trig_mask[s] = ctl[s].trig_en;
    end

    always_comb begin
        hit = st_hit | ld_now | (q.pend & ld_eq & {NUM_SLOTS{ld_valid}});
        d   = q;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (ld_arm[i])     d.pend[i] = 1'b1;
            else if (ld_valid) d.pend[i] = 1'b0;
        end
        d.brk  = |(hit & brk_mask);
        d.trig = hit & trig_mask;
        if (soft_rst) d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign brk_req  = q.brk;
    assign trig_out = q.trig;
endmodule

// File: rtl/dbrk_unit_chk.sv
`timescale 1ns/1ps
module dbrk_unit_chk #(
    parameter int NUM_SLOTS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 soft_rst,
    input logic                 debug_mode,
    input logic                 acc_valid,
    input logic                 ld_valid,
    input logic [31:0]          reg_rdata,
    input logic                 brk_req,
    input logic [NUM_SLOTS-1:0] trig_out,
    input logic [NUM_SLOTS-1:0] match_status
);
    // R7, R8: a request always leaves a sticky flag behind
    assert_brk_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> (match_status != '0));

    // R7, R8: each trigger pulse has its own flag set
    assert_trig_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out & ~match_status) == '0);

    // R9: port answers nothing outside debug mode
    assert_rd_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !debug_mode |-> (reg_rdata == '0));

    // R9: flags cannot be cleared outside debug mode
    assert_flags_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(debug_mode) && !$past(soft_rst)) |-> ((match_status & $past(match_status)) == $past(match_status)));

    // R8: flags only appear after an access or returning load data
    assert_flag_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(acc_valid) && !$past(ld_valid)) |-> ((match_status & ~$past(match_status)) == '0));

    // R10: soft reset clears flags and outputs
    assert_soft_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_rst) |-> (match_status == '0 && !brk_req && trig_out == '0));
endmodule

bind dbrk_unit dbrk_unit_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (.*);

// File: tb/dbrk_unit_test.sv
`timescale 1ns/1ps
module dbrk_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, soft_rst = 1'b0, debug_mode = 1'b1;
    logic        reg_en = 1'b0, reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        acc_valid = 1'b0, acc_store = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [7:0]  acc_asid = '0;
    logic [3:0]  acc_be = '0;
    logic [31:0] acc_wdata = '0;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_data = '0;
    logic        brk_req;
    logic [1:0]  trig_out, match_status;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dbrk_unit uut (.*);

    typedef struct packed {
        logic        st;
        logic [31:0] addr;
        logic [7:0]  asid;
        logic [3:0]  be;
        logic [31:0] wd;
        logic [1:0]  hit;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{1'b0, 32'h0000_1004, 8'd5, 4'hF, 32'h0,          2'b01}, // R1 masked low bits
        '{1'b1, 32'h0000_100C, 8'd5, 4'hF, 32'h0,          2'b01}, // R1 store
        '{1'b0, 32'h0000_1010, 8'd5, 4'hF, 32'h0,          2'b00}, // R1 unmasked bit differs
        '{1'b0, 32'h0000_1004, 8'd6, 4'hF, 32'h0,          2'b00}, // R2 asid differs
        '{1'b1, 32'h0000_2000, 8'd0, 4'h1, 32'hFFFF_ABCD, 2'b10}, // R5 masked upper lanes
        '{1'b1, 32'h0000_2000, 8'd0, 4'h1, 32'h1234_ABCE, 2'b00}, // R5 compared lane differs
        '{1'b1, 32'h0000_2000, 8'd0, 4'hC, 32'h1234_ABCD, 2'b00}, // R4 no lane overlap
        '{1'b0, 32'h0000_2000, 8'd0, 4'h1, 32'h1234_ABCD, 2'b00}, // R3 loads ignored
        '{1'b1, 32'h0000_2003, 8'd0, 4'h1, 32'h1234_ABCD, 2'b00}  // R1 no mask on slot 1
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1 v = reg_rdata;
        reg_en = 1'b0;
    endtask

    task automatic acc(input logic st, input logic [31:0] a, input logic [7:0] asid,
                       input logic [3:0] be, input logic [31:0] wd);
        @(negedge clk);
        acc_valid = 1'b1; acc_store = st; acc_addr = a; acc_asid = asid;
        acc_be = be; acc_wdata = wd;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset brk_req", 32'(brk_req), 0);
        chk("R10 reset trig_out", 32'(trig_out), 0);
        chk("R10 reset status", 32'(match_status), 0);
        rd(8'h03, v); chk("R10 reset ctrl", v, 0);

        // slot 0: addr 0x1000, low nibble masked, asid 5 compared, break enable, all lanes
        wr(8'h00, 32'h0000_1000); wr(8'h01, 32'h0000_000F); wr(8'h02, 32'd5);
        wr(8'h03, 32'h0000_0F11);
        // slot 1: addr 0x2000 exact, trigger only, loads ignored, data compare, lanes 0-1, lanes 2-3 masked
        wr(8'h10, 32'h0000_2000); wr(8'h11, 32'h0); wr(8'h14, 32'h1234_ABCD);
        wr(8'h13, 32'h000C_0326);
        rd(8'h13, v); chk("R11 ctrl readback", v, 32'h000C_0326);

        foreach (VECS[k]) begin
            wr(8'hF0, 32'h3);
            acc(VECS[k].st, VECS[k].addr, VECS[k].asid, VECS[k].be, VECS[k].wd);
            chk($sformatf("R7 vec%0d brk_req", k), 32'(brk_req), 32'(VECS[k].hit[0]));
            chk($sformatf("R7 vec%0d trig_out", k), 32'(trig_out), {31'b0, VECS[k].hit[1]} << 1);
            chk($sformatf("R8 vec%0d status", k), 32'(match_status), 32'(VECS[k].hit));
        end

        // R8: both flags sticky, then write-one clears only bit 0
        wr(8'hF0, 32'h3);
        acc(1'b0, 32'h0000_1004, 8'd5, 4'hF, 32'h0);
        acc(1'b1, 32'h0000_2000, 8'd0, 4'h1, 32'h0000_ABCD);
        @(negedge clk);
        chk("R8 sticky both", 32'(match_status), 3);
        wr(8'hF0, 32'h1);
        rd(8'hF0, v); chk("R8 w1c bit0", v, 2);

        // R8: clear and hit in the same cycle, the hit wins
        wr(8'hF0, 32'h3);
        acc(1'b1, 32'h0000_1000, 8'd5, 4'hF, 32'h0);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = 8'hF0; reg_wdata = 32'h1;
        acc_valid = 1'b1; acc_store = 1'b1; acc_addr = 32'h0000_1000; acc_asid = 8'd5; acc_be = 4'hF;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0; acc_valid = 1'b0;
        chk("R8 set wins over clear", 32'(match_status), 1);

        // R6: load data compare on slot 0
        wr(8'h03, 32'h0000_0F21); wr(8'h04, 32'hCAFE_F00D); wr(8'hF0, 32'h3);
        acc(1'b0, 32'h0000_1000, 8'd0, 4'hF, 32'h0);
        chk("R6 no request at access", 32'(brk_req), 0);
        repeat (2) @(negedge clk);
        ld_valid = 1'b1; ld_data = 32'hCAFE_F00D;
        #1 chk("R6 not before data edge", 32'(brk_req), 0);
        @(negedge clk);
        ld_valid = 1'b0;
        chk("R6 request after data", 32'(brk_req), 1);
        chk("R6 status after data", 32'(match_status), 1);
        wr(8'hF0, 32'h3);
        acc(1'b0, 32'h0000_1000, 8'd0, 4'hF, 32'h0);
        @(negedge clk);
        ld_valid = 1'b1; ld_data = 32'hCAFE_F00E;
        @(negedge clk);
        ld_valid = 1'b0;
        chk("R6 wrong data no request", 32'(brk_req), 0);
        chk("R5 store data mismatch ignored by load path", 32'(match_status), 0);

        // R3: stores ignored, loads allowed
        wr(8'h03, 32'h0000_0F09); wr(8'hF0, 32'h3);
        acc(1'b1, 32'h0000_1000, 8'd0, 4'hF, 32'h0);
        chk("R3 store ignored", 32'(match_status), 0);
        acc(1'b0, 32'h0000_1000, 8'd0, 4'hF, 32'h0);
        chk("R3 load hits", 32'(brk_req), 1);

        // R9: writes and reads gated by debug mode
        debug_mode = 1'b0;
        wr(8'h03, 32'h0);
        wr(8'hF0, 32'h3);
        rd(8'h03, v); chk("R9 read gated", v, 0);
        chk("R9 clear ignored", 32'(match_status), 1);
        debug_mode = 1'b1;
        rd(8'h03, v); chk("R9 write ignored", v, 32'h0000_0F09);

        // R10: soft reset
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        chk("R10 soft status", 32'(match_status), 0);
        rd(8'h03, v); chk("R10 soft ctrl", v, 0);
        acc(1'b0, 32'h0000_1000, 8'd0, 4'hF, 32'h0);
        chk("R10 disabled slot silent", 32'(brk_req), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule